// File: doc/BRIEF.md
# Beam Position Capture and Byte Readout

This block freezes the horizontal dot position and the vertical line position of a video timing generator into holding registers so that a processor can read them at leisure over an 8-bit register bus. Two things trigger a capture. One is a processor read of a dedicated trigger register while the capture-enable input is high. The other is a one-cycle pulse on the external strobe input, which captures whatever the enable input is doing.

Each held position is 9 bits wide and sits behind its own read register. Two successive reads of that register return the value: first the low byte, then the top bit. Each position register has its own byte-order flip-flop. A status register reports a sticky "capture happened" flag alongside fixed identification fields and the current interlace field, and reading it rewinds both byte-order flip-flops.

Every answered read loads a data-bus holding register, and that register drives `rd_data` from the cycle after the read onward. Bits that a read does not define keep their previous value.

Top module: `beam_latch_readout`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0x00, both held positions are 0, the sticky flag is 0 and both byte-order flip-flops select the low byte.
- R2: A read with `rd_sel`=0 (trigger) while `cap_enable` is 1 copies `dot_cnt` and `line_cnt` into the holding registers at that clock edge. With `cap_enable` at 0 the trigger read leaves them unchanged.
- R3: A trigger read places the `open_bus` value on `rd_data`.
- R4: A high `ext_strobe` captures both positions at that edge regardless of `cap_enable`.
- R5: A read with `rd_sel`=1 (horizontal) returns held dot bits 7:0 when its flip-flop is clear. When the flip-flop is set, it returns held dot bit 8 in data bit 0 and keeps data bits 7:1 from the previous `rd_data`. Each such read inverts the flip-flop.
- R6: A read with `rd_sel`=2 (vertical) behaves as in R5 for the held line position, using a flip-flop independent of the horizontal one.
- R7: A read with `rd_sel`=3 (status) clears both byte-order flip-flops, so the next read of each position register returns its low byte.
- R8: Status byte layout: bits 3:0 are `CHIP_VERSION`, bit 4 is `REGION_50HZ` (0 means 60 Hz, 1 means 50 Hz), bit 5 keeps the previous `rd_data` bit 5, and bit 7 is `field_odd`.
- R9: Status bit 6 reads 1 while `cap_enable` is 0, and the sticky flag is then left untouched. While `cap_enable` is 1, bit 6 returns the sticky flag and the flag is cleared.
- R10: Every capture sets the sticky flag. A capture in the same cycle as a clearing status read leaves the flag set.
- R11: `rd_data` changes only in the cycle after a read and holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read request for this cycle |
| rd_sel | input | 2 | Register select: 0 trigger, 1 horizontal, 2 vertical, 3 status |
| open_bus | input | 8 | Processor bus value returned by a trigger read |
| cap_enable | input | 1 | Enables trigger-read captures and the live status flag |
| ext_strobe | input | 1 | External capture pulse |
| dot_cnt | input | 9 | Live horizontal dot position |
| line_cnt | input | 9 | Live vertical line position |
| field_odd | input | 1 | Current interlace field |
| rd_data | output | 8 | Data-bus holding register |

## Verification
The bench sweeps many dot and line values across the full 9-bit range and reads each through both byte orders. A design that dropped bit 8 or disturbed the upper data bits on the second read would then return a wrong byte. It rewinds a half-read position with a status read; a design that failed to clear the flip-flops would return the top bit where the low byte belongs. It reads status with the enable low and then high, and a design that cleared the flag while forcing bit 6 would lose the capture report. It also fires the strobe during a clearing status read, so a design that let the clear win would lose that capture.

// File: rtl/beam_latch_pkg.sv
package beam_latch_pkg;

    localparam int BEAM_W = 9;
    localparam int BUS_W  = 8;

    typedef enum logic [1:0] {
        SEL_TRIGGER = 2'd0,
        SEL_HPOS    = 2'd1,
        SEL_VPOS    = 2'd2,
        SEL_STATUS  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BEAM_W-1:0] dot;
        logic [BEAM_W-1:0] line;
    } beam_hold_t;

    function automatic logic [BUS_W-1:0] pack_status(
        input logic [3:0] version,
        input logic       region,
        input logic       keep5,
        input logic       latched,
        input logic       fld
    );
        return {fld, latched, keep5, region, version};
    endfunction

endpackage

// File: rtl/beam_capture.sv
module beam_capture
    import beam_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_req,
    input  logic              clr_flag,
    input  logic [BEAM_W-1:0] dot_in,
    input  logic [BEAM_W-1:0] line_in,
    output beam_hold_t        hold_q,
    output logic              flag_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (cap_req) begin
            hold_q.dot  <= dot_in;
            hold_q.line <= line_in;
        end
    end

    // a fresh capture outranks a clearing status read
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (cap_req)
            flag_q <= 1'b1;
        else if (clr_flag)
            flag_q <= 1'b0;
    end

endmodule

// File: rtl/beam_byte_port.sv
module beam_byte_port #(
    parameter int VAL_W = 9,
    parameter int DAT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_hit,
    input  logic             rewind,
    input  logic [VAL_W-1:0] value,
    input  logic [DAT_W-1:0] bus_prev,
    output logic [DAT_W-1:0] byte_out,
    output logic             hi_sel_q
);

    localparam int HI_W = VAL_W - DAT_W;
    localparam logic [DAT_W-1:0] HI_MASK = DAT_W'((1 << HI_W) - 1);

    logic [DAT_W-1:0] hi_part;

    assign hi_part  = DAT_W'(value[VAL_W-1:DAT_W]);
    assign byte_out = hi_sel_q ? ((bus_prev & ~HI_MASK) | hi_part)
                               : value[DAT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || rewind)
            hi_sel_q <= 1'b0;
        else if (rd_hit)
            hi_sel_q <= ~hi_sel_q;
    end

endmodule

// File: rtl/beam_latch_readout.sv
module beam_latch_readout
    import beam_latch_pkg::*;
#(
    parameter logic [3:0] CHIP_VERSION = 4'd3,
    parameter logic       REGION_50HZ  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    input  logic [BUS_W-1:0]  open_bus,
    input  logic              cap_enable,
    input  logic              ext_strobe,
    input  logic [BEAM_W-1:0] dot_cnt,
    input  logic [BEAM_W-1:0] line_cnt,
    input  logic              field_odd,
    output logic [BUS_W-1:0]  rd_data
);

    localparam int NPORT = 2;

    reg_sel_e          sel;
    logic              rd_trig, rd_stat, cap_req, clr_flag, flag_q;
    beam_hold_t        hold_q;
    logic [BUS_W-1:0]  bus_q, bus_d;
    logic [BEAM_W-1:0] port_val  [NPORT];
    logic [BUS_W-1:0]  port_byte [NPORT];
    logic              port_hit  [NPORT];
    logic              port_tog  [NPORT];

    assign sel      = reg_sel_e'(rd_sel);
    assign rd_trig  = rd_en && (sel == SEL_TRIGGER);
    assign rd_stat  = rd_en && (sel == SEL_STATUS);
    assign cap_req  = ext_strobe || (rd_trig && cap_enable);
    assign clr_flag = rd_stat && cap_enable;

    beam_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .cap_req  (cap_req),
        .clr_flag (clr_flag),
        .dot_in   (dot_cnt),
        .line_in  (line_cnt),
        .hold_q   (hold_q),
        .flag_q   (flag_q)
    );

    assign port_val[0] = hold_q.dot;
    assign port_val[1] = hold_q.line;
    assign port_hit[0] = rd_en && (sel == SEL_HPOS);
    assign port_hit[1] = rd_en && (sel == SEL_VPOS);

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            beam_byte_port #(
                .VAL_W (BEAM_W),
                .DAT_W (BUS_W)
            ) u_port (
                .clk      (clk),
                .rst      (rst),
                .rd_hit   (port_hit[p]),
                .rewind   (rd_stat),
                .value    (port_val[p]),
                .bus_prev (bus_q),
                .byte_out (port_byte[p]),
                .hi_sel_q (port_tog[p])
            );
        end
    endgenerate

    always_comb begin
        bus_d = bus_q;
        if (rd_en) begin
            unique case (sel)
                SEL_TRIGGER: bus_d = open_bus;
                SEL_HPOS:    bus_d = port_byte[0];
                SEL_VPOS:    bus_d = port_byte[1];
                SEL_STATUS:  bus_d = pack_status(CHIP_VERSION, REGION_50HZ, bus_q[5],
                                                 cap_enable ? flag_q : 1'b1, field_odd);
                default:     bus_d = bus_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_q <= '0;
        else
            bus_q <= bus_d;
    end

    assign rd_data = bus_q;

endmodule

// File: rtl/beam_latch_checker.sv
module beam_latch_checker
    import beam_latch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [1:0]        rd_sel,
    input logic [BUS_W-1:0]  open_bus,
    input logic              cap_enable,
    input logic              ext_strobe,
    input logic [BEAM_W-1:0] dot_cnt,
    input logic [BEAM_W-1:0] line_cnt,
    input logic [BUS_W-1:0]  rd_data,
    input beam_hold_t        hold,
    input logic              flag,
    input logic              h_tog,
    input logic              v_tog
);

    logic capture;
    assign capture = ext_strobe || (rd_en && rd_sel == 2'd0 && cap_enable);

    AST_TRIG_OPEN_BUS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd0) |=> rd_data == $past(open_bus)); // R3

    AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (rst)
        capture |=> (hold.dot == $past(dot_cnt) && hold.line == $past(line_cnt) && flag)); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ($stable(hold.dot) && $stable(hold.line))); // R2

    AST_STATUS_FORCED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd3 && !cap_enable) |=> rd_data[6]); // R9

    AST_STATUS_REWIND: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd3) |=> (!h_tog && !v_tog)); // R7

    AST_H_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd1) |=> (h_tog != $past(h_tog) && $stable(v_tog))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R11

endmodule

bind beam_latch_readout beam_latch_checker i_checker (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .open_bus   (open_bus),
    .cap_enable (cap_enable),
    .ext_strobe (ext_strobe),
    .dot_cnt    (dot_cnt),
    .line_cnt   (line_cnt),
    .rd_data    (rd_data),
    .hold       (hold_q),
    .flag       (flag_q),
    .h_tog      (port_tog[0]),
    .v_tog      (port_tog[1])
);

// File: tb/test_beam_latch_readout.sv
module test_beam_latch_readout;

    localparam logic [3:0] VER    = 4'd3;
    localparam logic       REGION = 1'b0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_en = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] open_bus = 8'h00;
    logic       cap_enable = 1'b0;
    logic       ext_strobe = 1'b0;
    logic [8:0] dot_cnt = 9'd0;
    logic [8:0] line_cnt = 9'd0;
    logic       field_odd = 1'b0;
    logic [7:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] m_bus  = 8'h00;
    logic [8:0] m_dot  = 9'd0;
    logic [8:0] m_line = 9'd0;
    logic       m_flag = 1'b0;
    logic       m_ht   = 1'b0;
    logic       m_vt   = 1'b0;

    beam_latch_readout #(.CHIP_VERSION(VER), .REGION_50HZ(REGION)) i_beam_latch_readout (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel), .open_bus(open_bus),
        .cap_enable(cap_enable), .ext_strobe(ext_strobe), .dot_cnt(dot_cnt),
        .line_cnt(line_cnt), .field_odd(field_odd), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // one read (optionally with a same-cycle strobe), model update and check
    task automatic access(input int sel, input bit strobe, input string req);
        logic [7:0] exp;
        bit cap;
        cap = strobe || (sel == 0 && cap_enable);
        case (sel)
            0: exp = open_bus;
            1: begin exp = m_ht ? {m_bus[7:1], m_dot[8]}  : m_dot[7:0];  m_ht = ~m_ht; end
            2: begin exp = m_vt ? {m_bus[7:1], m_line[8]} : m_line[7:0]; m_vt = ~m_vt; end
            default: begin
                exp = {field_odd, cap_enable ? m_flag : 1'b1, m_bus[5], REGION, VER};
                m_ht = 1'b0; m_vt = 1'b0;
                if (cap_enable) m_flag = 1'b0;
            end
        endcase
        if (cap) begin m_dot = dot_cnt; m_line = line_cnt; m_flag = 1'b1; end
        m_bus = exp;
        @(negedge clk);
        rd_en = 1'b1; rd_sel = 2'(sel); ext_strobe = strobe;
        @(negedge clk);
        rd_en = 1'b0; ext_strobe = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic strobe_only();
        @(negedge clk);
        ext_strobe = 1'b1;
        @(negedge clk);
        ext_strobe = 1'b0;
        m_dot = dot_cnt; m_line = line_cnt; m_flag = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset bus", rd_data, 8'h00);
        cap_enable = 1'b1;
        access(3, 1'b0, "R1 status flag clear");
        access(1, 1'b0, "R1 held dot low");
        access(1, 1'b0, "R1 held dot high");
        access(2, 1'b0, "R1 held line low");

        // R2 R5 R6 sweep over the whole 9-bit range
        for (int d = 0; d < 512; d += 7) begin
            dot_cnt   = 9'(d);
            line_cnt  = 9'((d * 5 + 300) % 512);
            open_bus  = 8'(d * 3);
            field_odd = d[1];
            access(3, 1'b0, "R7 rewind");
            access(0, 1'b0, "R2 trigger capture");
            dot_cnt = ~dot_cnt; line_cnt = ~line_cnt;
            access(1, 1'b0, "R5 dot low byte");
            access(2, 1'b0, "R6 line low byte");
            access(2, 1'b0, "R6 line top bit");
            access(1, 1'b0, "R5 dot top bit");
        end

        // R2 disabled trigger leaves holding registers alone
        dot_cnt = 9'h1A5; line_cnt = 9'h0F3; cap_enable = 1'b0; open_bus = 8'h5C;
        access(0, 1'b0, "R3 trigger open bus");
        access(3, 1'b0, "R9 forced bit6");
        access(1, 1'b0, "R2 no capture when disabled");
        access(1, 1'b0, "R2 no capture when disabled hi");

        // R4 strobe with enable low
        dot_cnt = 9'h1FF; line_cnt = 9'h100;
        strobe_only();
        access(1, 1'b0, "R4 strobe dot");
        access(1, 1'b0, "R4 strobe dot hi");
        access(2, 1'b0, "R4 strobe line");
        access(2, 1'b0, "R4 strobe line hi");

        // R9 flag survives forced status reads, then clears
        access(3, 1'b0, "R9 forced while low");
        cap_enable = 1'b1;
        access(3, 1'b0, "R9 flag reported");
        access(3, 1'b0, "R9 flag cleared");

        // R8 bit5 carry and field/region
        open_bus = 8'h20; field_odd = 1'b1;
        access(0, 1'b0, "R3 trigger open bus 20");
        access(3, 1'b0, "R8 bit5 kept");
        open_bus = 8'hDF;
        access(0, 1'b0, "R3 trigger open bus DF");
        access(3, 1'b0, "R8 bit5 clear kept");

        // R7 rewind mid-sequence
        access(1, 1'b0, "R7 dot low");
        access(3, 1'b0, "R7 status");
        access(1, 1'b0, "R7 dot low again");

        // R10 strobe during a clearing status read
        dot_cnt = 9'h0AA; line_cnt = 9'h155;
        access(3, 1'b1, "R10 status with strobe");
        access(3, 1'b0, "R10 flag kept set");

        // R11 idle holds rd_data
        repeat (5) @(negedge clk);
        check("R11 idle hold", rd_data, m_bus);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule